// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-purpose register operations of a small RISC core. The core presents a base operand and an immediate offset; the block ORs them into a register address. Bits 15:11 of that address select a register group, and bits 10:0 select a register number within the group. Reads return data combinationally. A write takes effect on the clock edge at which the write strobe is high.

The block holds the version word, the program-counter copies, the status register, the exception save registers and the interrupt mask and pending registers. It also exposes way 0 of the data and instruction TLB match and translate arrays. Some writes have side effects. The block reports them as registered one-cycle pulses: a request to flush the whole TLB, and a request to flush one page together with its page-aligned address. The tick timer lives outside the block and is reached through a small side port.

Top module: `spr_access_unit`

## Requirements
- R1: The access address is `accBase | accOffset` (offset zero-extended). The group is address bits 15:11 and the number is bits 10:0. Any set bit in 31:16 makes the access unmapped.
- R2: The version (group 0, number 0), next PC (0/16), previous PC (0/18), exception PC (0/32), exception address (0/48) and exception status (0/64) are plain registers. A write is stored at the edge and read back unchanged.
- R3: After reset every register reads zero, except the status register, which reads 0x00008001 (supervisor bit 0 and fixed-one bit 15 set).
- R4: A status register write (0/17) stores the written value with bit 15 forced to 1.
- R5: If a status write changes bit 0 (supervisor), bit 5 (data MMU enable) or bit 6 (instruction MMU enable), `flushAll` is high for exactly the cycle after the write edge. Otherwise it stays low.
- R6: A write to the interrupt mask (9/0) ORs the written value into the stored mask.
- R7: The interrupt pending register (9/2) sets every bit whose `irqLines` bit is high at an edge. A write to it clears the bits written as 1. A bit that is both set and cleared in the same edge stays set.
- R8: Data TLB entry i has its match word at group 1 number 512+i and its translate word at 1/640+i, for i < TLB_ENTRIES. The instruction TLB uses the same numbers in group 2.
- R9: A match-word write with bit 0 equal to 0 raises `flushPage` for the cycle after the edge. In that cycle `flushPageAddr` carries the previous match word with bits 12:0 cleared. Otherwise `flushPageAddr` is zero.
- R10: Writes to unmapped addresses are ignored. These include TLB ways 1 to 3 (numbers 768 to 1535 in groups 1 and 2) and entries at or beyond TLB_ENTRIES. Reads of such addresses return `destIn` unchanged.
- R11: The timer mode (10/0) and counter (10/1) read as `tmrModeIn` and `tmrCountIn`. A write to either raises `tmrWrEn` in the same cycle, with `tmrSel` (0 mode, 1 counter) and `tmrWrData` equal to the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the current access |
| accBase | input | 32 | Base operand of the address |
| accOffset | input | 16 | Immediate offset ORed into the address |
| wrData | input | 32 | Value to write |
| destIn | input | 32 | Current destination value, returned on unmapped reads |
| irqLines | input | 32 | Interrupt lines that set pending bits |
| tmrModeIn | input | 32 | Timer mode value from the timer |
| tmrCountIn | input | 32 | Timer count value from the timer |
| rdData | output | 32 | Combinational read result |
| tmrWrEn | output | 1 | Timer register write strobe |
| tmrSel | output | 1 | Timer register select (0 mode, 1 count) |
| tmrWrData | output | 32 | Data for the timer write |
| flushAll | output | 1 | One-cycle whole-TLB flush request |
| flushPage | output | 1 | One-cycle single-page flush request |
| flushPageAddr | output | 32 | Page address for the page flush |

## Verification
`rdData`, `tmrWrEn`, `tmrSel` and `tmrWrData` are combinational, so the bench checks them 1 ns after driving the inputs, in the same cycle. A stored value becomes visible to a read in the cycle after its write edge. The flush pulses come from one register stage, so they are due in the cycle after the write edge. The bench checks them at the next falling edge against a behavioural model, which the bench updates at every rising edge, including the pending-bit set from `irqLines`.

// File: rtl/spr_access_pkg.sv
package sprAccessPkg;
  localparam int DATA_W = 32;
  localparam int OFF_W = 16;

  // status register bit positions
  localparam int SR_SUPER = 0;
  localparam int SR_DMMU = 5;
  localparam int SR_IMMU = 6;
  localparam int SR_FIXED = 15;
  localparam logic [DATA_W-1:0] SR_MMU_MASK =
    (DATA_W'(1) << SR_SUPER) | (DATA_W'(1) << SR_DMMU) | (DATA_W'(1) << SR_IMMU);
  localparam logic [DATA_W-1:0] SR_FIXED_BIT = DATA_W'(1) << SR_FIXED;
  localparam logic [DATA_W-1:0] SR_RESET = SR_FIXED_BIT | (DATA_W'(1) << SR_SUPER);

  typedef enum logic [3:0] {
    RD_NONE, RD_VER, RD_NPC, RD_STAT, RD_PPC, RD_EPC, RD_EADR, RD_ESTAT,
    RD_IMASK, RD_IPEND, RD_TMODE, RD_TCOUNT, RD_DMATCH, RD_DXLATE,
    RD_IMATCH, RD_IXLATE
  } rdSel_e;

  typedef struct packed {
    logic wrVer;
    logic wrNpc;
    logic wrStat;
    logic wrPpc;
    logic wrEpc;
    logic wrEadr;
    logic wrEstat;
    logic wrImask;
    logic wrIpend;
    logic wrDMatch;
    logic wrDXlate;
    logic wrIMatch;
    logic wrIXlate;
  } sprStrobe_t;
endpackage

// File: rtl/spr_ctrl.sv
module spr_ctrl
  import sprAccessPkg::*;
#(
  parameter int TLB_ENTRIES = 16,
  parameter int IDX_W = $clog2(TLB_ENTRIES)
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] accBase,
  input  logic [OFF_W-1:0]  accOffset,
  output sprStrobe_t        strobe,
  output rdSel_e            rdSel,
  output logic [IDX_W-1:0]  tlbIdx,
  output logic              tmrWrEn,
  output logic              tmrSel
);
  localparam logic [10:0] MATCH_BASE = 11'd512;
  localparam logic [10:0] XLATE_BASE = 11'd640;
  localparam logic [10:0] MATCH_END = 11'(512 + TLB_ENTRIES);
  localparam logic [10:0] XLATE_END = 11'(640 + TLB_ENTRIES);

  logic [DATA_W-1:0] addr;
  logic [4:0]        grp;
  logic [10:0]       num;
  logic [10:0]       offs;
  logic              hiClear;

  always_comb begin
    addr    = accBase | DATA_W'(accOffset);
    grp     = addr[15:11];
    num     = addr[10:0];
    hiClear = (addr[DATA_W-1:16] == '0);
    rdSel   = RD_NONE;
    offs    = '0;
    if (hiClear) begin
      unique case (grp)
        5'd0: begin
          case (num)
            11'd0:   rdSel = RD_VER;
            11'd16:  rdSel = RD_NPC;
            11'd17:  rdSel = RD_STAT;
            11'd18:  rdSel = RD_PPC;
            11'd32:  rdSel = RD_EPC;
            11'd48:  rdSel = RD_EADR;
            11'd64:  rdSel = RD_ESTAT;
            default: rdSel = RD_NONE;
          endcase
        end
        5'd1, 5'd2: begin
          if (num >= MATCH_BASE && num < MATCH_END) begin
            rdSel = (grp == 5'd1) ? RD_DMATCH : RD_IMATCH;
            offs  = num - MATCH_BASE;
          end else if (num >= XLATE_BASE && num < XLATE_END) begin
            rdSel = (grp == 5'd1) ? RD_DXLATE : RD_IXLATE;
            offs  = num - XLATE_BASE;
          end
        end
        5'd9: begin
          if (num == 11'd0) rdSel = RD_IMASK;
          else if (num == 11'd2) rdSel = RD_IPEND;
        end
        5'd10: begin
          if (num == 11'd0) rdSel = RD_TMODE;
          else if (num == 11'd1) rdSel = RD_TCOUNT;
        end
        default: rdSel = RD_NONE;
      endcase
    end
    tlbIdx = IDX_W'(offs);
  end

  always_comb begin
    strobe          = '0;
    strobe.wrVer    = wrEn && (rdSel == RD_VER);
    strobe.wrNpc    = wrEn && (rdSel == RD_NPC);
    strobe.wrStat   = wrEn && (rdSel == RD_STAT);
    strobe.wrPpc    = wrEn && (rdSel == RD_PPC);
    strobe.wrEpc    = wrEn && (rdSel == RD_EPC);
    strobe.wrEadr   = wrEn && (rdSel == RD_EADR);
    strobe.wrEstat  = wrEn && (rdSel == RD_ESTAT);
    strobe.wrImask  = wrEn && (rdSel == RD_IMASK);
    strobe.wrIpend  = wrEn && (rdSel == RD_IPEND);
    strobe.wrDMatch = wrEn && (rdSel == RD_DMATCH);
    strobe.wrDXlate = wrEn && (rdSel == RD_DXLATE);
    strobe.wrIMatch = wrEn && (rdSel == RD_IMATCH);
    strobe.wrIXlate = wrEn && (rdSel == RD_IXLATE);
    tmrWrEn         = wrEn && (rdSel == RD_TMODE || rdSel == RD_TCOUNT);
    tmrSel          = (rdSel == RD_TCOUNT);
  end
endmodule

// File: rtl/spr_datapath.sv
module spr_datapath
  import sprAccessPkg::*;
#(
  parameter int TLB_ENTRIES = 16,
  parameter int IDX_W = $clog2(TLB_ENTRIES),
  parameter int PAGE_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  sprStrobe_t        strobe,
  input  rdSel_e            rdSel,
  input  logic [IDX_W-1:0]  tlbIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] destIn,
  input  logic [DATA_W-1:0] irqLines,
  input  logic [DATA_W-1:0] tmrModeIn,
  input  logic [DATA_W-1:0] tmrCountIn,
  output logic [DATA_W-1:0] rdData,
  output logic              flushAll,
  output logic              flushPage,
  output logic [DATA_W-1:0] flushPageAddr,
  output logic [DATA_W-1:0] statQ,
  output logic [DATA_W-1:0] imaskQ
);
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_BITS) - DATA_W'(1));

  logic [DATA_W-1:0] verQ, npcQ, ppcQ, epcQ, eadrQ, estatQ, ipendQ;
  logic [DATA_W-1:0] dMatch [TLB_ENTRIES];
  logic [DATA_W-1:0] dXlate [TLB_ENTRIES];
  logic [DATA_W-1:0] iMatch [TLB_ENTRIES];
  logic [DATA_W-1:0] iXlate [TLB_ENTRIES];
  logic [DATA_W-1:0] oldMatch;
  logic              pageHit;
  logic              modeFlip;

  // plain and side-effect registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      verQ   <= '0;
      npcQ   <= '0;
      ppcQ   <= '0;
      epcQ   <= '0;
      eadrQ  <= '0;
      estatQ <= '0;
      statQ  <= SR_RESET;
      imaskQ <= '0;
      ipendQ <= '0;
    end else begin
      if (strobe.wrVer)   verQ   <= wrData;
      if (strobe.wrNpc)   npcQ   <= wrData;
      if (strobe.wrPpc)   ppcQ   <= wrData;
      if (strobe.wrEpc)   epcQ   <= wrData;
      if (strobe.wrEadr)  eadrQ  <= wrData;
      if (strobe.wrEstat) estatQ <= wrData;
      if (strobe.wrStat)  statQ  <= wrData | SR_FIXED_BIT;
      if (strobe.wrImask) imaskQ <= imaskQ | wrData;
      ipendQ <= (ipendQ & ~(strobe.wrIpend ? wrData : '0)) | irqLines;
    end
  end

  // way-0 TLB arrays
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < TLB_ENTRIES; e++) begin
        dMatch[e] <= '0;
        dXlate[e] <= '0;
        iMatch[e] <= '0;
        iXlate[e] <= '0;
      end
    end else begin
      for (int e = 0; e < TLB_ENTRIES; e++) begin
        if (tlbIdx == IDX_W'(e)) begin
          if (strobe.wrDMatch) dMatch[e] <= wrData;
          if (strobe.wrDXlate) dXlate[e] <= wrData;
          if (strobe.wrIMatch) iMatch[e] <= wrData;
          if (strobe.wrIXlate) iXlate[e] <= wrData;
        end
      end
    end
  end

  // flush request generation
  always_comb begin
    oldMatch = strobe.wrDMatch ? dMatch[tlbIdx] : iMatch[tlbIdx];
    pageHit  = (strobe.wrDMatch || strobe.wrIMatch) && !wrData[0];
    modeFlip = strobe.wrStat && (((statQ ^ wrData) & SR_MMU_MASK) != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushAll      <= 1'b0;
      flushPage     <= 1'b0;
      flushPageAddr <= '0;
    end else begin
      flushAll      <= modeFlip;
      flushPage     <= pageHit;
      flushPageAddr <= pageHit ? (oldMatch & PAGE_MASK) : '0;
    end
  end

  // combinational read mux
  always_comb begin
    unique case (rdSel)
      RD_VER:    rdData = verQ;
      RD_NPC:    rdData = npcQ;
      RD_STAT:   rdData = statQ;
      RD_PPC:    rdData = ppcQ;
      RD_EPC:    rdData = epcQ;
      RD_EADR:   rdData = eadrQ;
      RD_ESTAT:  rdData = estatQ;
      RD_IMASK:  rdData = imaskQ;
      RD_IPEND:  rdData = ipendQ;
      RD_TMODE:  rdData = tmrModeIn;
      RD_TCOUNT: rdData = tmrCountIn;
      RD_DMATCH: rdData = dMatch[tlbIdx];
      RD_DXLATE: rdData = dXlate[tlbIdx];
      RD_IMATCH: rdData = iMatch[tlbIdx];
      RD_IXLATE: rdData = iXlate[tlbIdx];
      default:   rdData = destIn;
    endcase
  end
endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import sprAccessPkg::*;
#(
  parameter int TLB_ENTRIES = 16,
  parameter int PAGE_BITS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       accBase,
  input  logic [15:0]       accOffset,
  input  logic [31:0]       wrData,
  input  logic [31:0]       destIn,
  input  logic [31:0]       irqLines,
  input  logic [31:0]       tmrModeIn,
  input  logic [31:0]       tmrCountIn,
  output logic [31:0]       rdData,
  output logic              tmrWrEn,
  output logic              tmrSel,
  output logic [31:0]       tmrWrData,
  output logic              flushAll,
  output logic              flushPage,
  output logic [31:0]       flushPageAddr
);
  localparam int IDX_W = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;

  sprStrobe_t        strobe;
  rdSel_e            rdSel;
  logic [IDX_W-1:0]  tlbIdx;
  logic [DATA_W-1:0] statQ;
  logic [DATA_W-1:0] imaskQ;

  spr_ctrl #(.TLB_ENTRIES(TLB_ENTRIES), .IDX_W(IDX_W)) ctrl_i (
    .wrEn(wrEn), .accBase(accBase), .accOffset(accOffset),
    .strobe(strobe), .rdSel(rdSel), .tlbIdx(tlbIdx),
    .tmrWrEn(tmrWrEn), .tmrSel(tmrSel)
  );

  spr_datapath #(.TLB_ENTRIES(TLB_ENTRIES), .IDX_W(IDX_W), .PAGE_BITS(PAGE_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .tlbIdx(tlbIdx),
    .wrData(wrData), .destIn(destIn), .irqLines(irqLines),
    .tmrModeIn(tmrModeIn), .tmrCountIn(tmrCountIn), .rdData(rdData),
    .flushAll(flushAll), .flushPage(flushPage), .flushPageAddr(flushPageAddr),
    .statQ(statQ), .imaskQ(imaskQ)
  );

  assign tmrWrData = wrData;
endmodule

// File: rtl/spr_access_checker.sv
module spr_access_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        flushAll,
  input logic        flushPage,
  input logic [31:0] statQ,
  input logic [31:0] imaskQ
);
  assert_fixed_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    statQ[15]);

  assert_mask_keeps_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((imaskQ & $past(imaskQ)) == $past(imaskQ)));

  assert_flush_needs_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    flushAll |-> $past(wrEn));

  assert_page_needs_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    flushPage |-> $past(wrEn));

  assert_one_flush_kind_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flushAll, flushPage}));
endmodule

bind spr_access_unit spr_access_checker chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .flushAll(flushAll),
  .flushPage(flushPage), .statQ(statQ), .imaskQ(imaskQ)
);

// File: tb/spr_access_unit_tb_top.sv
module spr_access_unit_tb_top;
  localparam int TLB_N = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] accBase = '0, wrData = '0, destIn = '0, irqLines = '0;
  logic [15:0] accOffset = '0;
  logic [31:0] tmrModeIn = 32'h0000_00A5, tmrCountIn = 32'h0001_2345;
  logic [31:0] rdData, tmrWrData, flushPageAddr;
  logic        tmrWrEn, tmrSel, flushAll, flushPage;

  spr_access_unit #(.TLB_ENTRIES(TLB_N)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .accBase(accBase), .accOffset(accOffset),
    .wrData(wrData), .destIn(destIn), .irqLines(irqLines), .tmrModeIn(tmrModeIn),
    .tmrCountIn(tmrCountIn), .rdData(rdData), .tmrWrEn(tmrWrEn), .tmrSel(tmrSel),
    .tmrWrData(tmrWrData), .flushAll(flushAll), .flushPage(flushPage),
    .flushPageAddr(flushPageAddr)
  );

  int errCnt = 0;
  int chkCnt = 0;

  // behavioural reference state
  logic [31:0] mVer, mNpc, mPpc, mEpc, mEadr, mEstat, mStat, mMask, mPend;
  logic [31:0] mDM [TLB_N];
  logic [31:0] mDX [TLB_N];
  logic [31:0] mIM [TLB_N];
  logic [31:0] mIX [TLB_N];
  logic        mFlushAll, mFlushPage;
  logic [31:0] mFlushAddr;

  function automatic logic [31:0] spa(int g, int n);
    return 32'((g << 11) + n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    mVer = 0; mNpc = 0; mPpc = 0; mEpc = 0; mEadr = 0; mEstat = 0;
    mStat = 32'h0000_8001; mMask = 0; mPend = 0;
    for (int i = 0; i < TLB_N; i++) begin
      mDM[i] = 0; mDX[i] = 0; mIM[i] = 0; mIX[i] = 0;
    end
    mFlushAll = 0; mFlushPage = 0; mFlushAddr = 0;
  endtask

  function automatic logic [31:0] mRead(logic [31:0] a, logic [31:0] d);
    int g, n;
    if (a[31:16] != 0) return d;
    g = int'(a[15:11]);
    n = int'(a[10:0]);
    if (g == 0) begin
      if (n == 0) return mVer;
      if (n == 16) return mNpc;
      if (n == 17) return mStat;
      if (n == 18) return mPpc;
      if (n == 32) return mEpc;
      if (n == 48) return mEadr;
      if (n == 64) return mEstat;
    end else if (g == 1 || g == 2) begin
      if (n >= 512 && n < 512 + TLB_N) return (g == 1) ? mDM[n-512] : mIM[n-512];
      if (n >= 640 && n < 640 + TLB_N) return (g == 1) ? mDX[n-640] : mIX[n-640];
    end else if (g == 9) begin
      if (n == 0) return mMask;
      if (n == 2) return mPend;
    end else if (g == 10) begin
      if (n == 0) return tmrModeIn;
      if (n == 1) return tmrCountIn;
    end
    return d;
  endfunction

  // updates the model at a write edge; pending register handled by caller
  task automatic mWrite(logic [31:0] a, logic [31:0] v);
    int g, n;
    if (a[31:16] != 0) return;
    g = int'(a[15:11]);
    n = int'(a[10:0]);
    if (g == 0) begin
      if (n == 0) mVer = v;
      if (n == 16) mNpc = v;
      if (n == 18) mPpc = v;
      if (n == 32) mEpc = v;
      if (n == 48) mEadr = v;
      if (n == 64) mEstat = v;
      if (n == 17) begin
        if ((mStat[0] != v[0]) || (mStat[5] != v[5]) || (mStat[6] != v[6])) mFlushAll = 1;
        mStat = v | 32'h0000_8000;
      end
    end else if (g == 1 || g == 2) begin
      if (n >= 512 && n < 512 + TLB_N) begin
        if (!v[0]) begin
          mFlushPage = 1;
          mFlushAddr = ((g == 1) ? mDM[n-512] : mIM[n-512]) & 32'hFFFF_E000;
        end
        if (g == 1) mDM[n-512] = v; else mIM[n-512] = v;
      end else if (n >= 640 && n < 640 + TLB_N) begin
        if (g == 1) mDX[n-640] = v; else mIX[n-640] = v;
      end
    end else if (g == 9 && n == 0) begin
      mMask = mMask | v;
    end
  endtask

  // one access: drive at the falling edge, check combinational results,
  // advance the model at the rising edge, check registered pulses after it
  task automatic op(bit w, logic [31:0] base, logic [15:0] off, logic [31:0] data,
                    logic [31:0] dest, logic [31:0] irq, string req);
    logic [31:0] a;
    logic [31:0] clr;
    bit          tmrHit;
    wrEn = w; accBase = base; accOffset = off; wrData = data; destIn = dest; irqLines = irq;
    #1;
    a = base | {16'h0, off};
    check(req, rdData, mRead(a, dest));
    tmrHit = w && (a == spa(10, 0) || a == spa(10, 1));
    check({req, " R11 tmrWrEn"}, {31'h0, tmrWrEn}, {31'h0, tmrHit});
    if (tmrHit) begin
      check("R11 tmrSel", {31'h0, tmrSel}, {31'h0, (a == spa(10, 1))});
      check("R11 tmrWrData", tmrWrData, data);
    end
    @(posedge clk);
    mFlushAll = 0; mFlushPage = 0; mFlushAddr = 0;
    clr = (w && a == spa(9, 2)) ? data : 32'h0;
    if (w) mWrite(a, data);
    mPend = (mPend & ~clr) | irq;
    @(negedge clk);
    check({req, " R5 flushAll"}, {31'h0, flushAll}, {31'h0, mFlushAll});
    check({req, " R9 flushPage"}, {31'h0, flushPage}, {31'h0, mFlushPage});
    check({req, " R9 flushPageAddr"}, flushPageAddr, mFlushAddr);
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R3: reset values
    op(0, spa(0, 17), 0, 0, 32'hDEAD_0001, 0, "R3 status reset");
    op(0, spa(0, 0), 0, 0, 32'hDEAD_0002, 0, "R3 version reset");
    op(0, spa(9, 0), 0, 0, 32'hDEAD_0003, 0, "R3 mask reset");
    op(0, spa(1, 512), 0, 0, 32'hDEAD_0004, 0, "R3 tlb reset");

    // R2: plain registers, R1: OR-formed address
    op(1, spa(0, 16), 0, 32'h1000_0040, 0, 0, "R2 npc write");
    op(1, spa(0, 0), 16'd18, 32'h2000_0044, 0, 0, "R1 base|offset ppc write");
    op(1, spa(0, 32), 0, 32'h3000_0100, 0, 0, "R2 epc write");
    op(1, 32'h0, 16'd48, 32'h4444_4444, 0, 0, "R2 eadr write");
    op(1, spa(0, 64), 0, 32'h0000_00F3, 0, 0, "R2 estat write");
    op(1, spa(0, 0), 0, 32'h1200_0034, 0, 0, "R2 version write");
    op(0, spa(0, 16), 0, 0, 1, 0, "R2 npc read");
    op(0, spa(0, 18), 0, 0, 2, 0, "R2 ppc read");
    op(0, spa(0, 48), 0, 0, 3, 0, "R2 eadr read");
    op(0, spa(0, 0), 16'd64, 0, 4, 0, "R1 offset estat read");
    op(1, 32'h0001_0000, 16'd16, 32'hBAD0_BAD0, 32'h0000_7777, 0, "R1 high bits unmapped");
    op(0, spa(0, 16), 0, 0, 5, 0, "R1 npc untouched");

    // R4/R5: status writes
    op(1, spa(0, 17), 0, 32'h0000_0001, 0, 0, "R4 status no mode change");
    op(0, spa(0, 17), 0, 0, 0, 0, "R4 fixed bit forced");
    op(1, spa(0, 17), 0, 32'h0000_0061, 0, 0, "R5 enable mmu bits");
    op(1, spa(0, 17), 0, 32'h0000_8461, 0, 0, "R5 non-mode bit only");
    op(1, spa(0, 17), 0, 32'h0000_0460, 0, 0, "R5 supervisor cleared");
    op(0, spa(0, 17), 0, 0, 0, 0, "R4 status read");

    // R6: OR-only mask
    op(1, spa(9, 0), 0, 32'h0000_00F0, 0, 0, "R6 mask first");
    op(1, spa(9, 0), 0, 32'h0000_0F01, 0, 0, "R6 mask second");
    op(1, spa(9, 0), 0, 32'h0000_0000, 0, 0, "R6 mask zero");
    op(0, spa(9, 0), 0, 0, 0, 0, "R6 mask read");

    // R7: pending set and clear
    op(0, spa(9, 2), 0, 0, 0, 32'h0000_00FF, "R7 irq set");
    op(1, spa(9, 2), 0, 32'h0000_000F, 0, 0, "R7 clear low nibble");
    op(0, spa(9, 2), 0, 0, 0, 0, "R7 pend read");
    op(1, spa(9, 2), 0, 32'h0000_00F0, 0, 32'h0000_0080, "R7 set wins over clear");
    op(0, spa(9, 2), 0, 0, 0, 0, "R7 pend after collision");

    // R8/R9: TLB way 0
    op(1, spa(1, 512 + 3), 0, 32'h1234_5679, 0, 0, "R8 dtlb match write");
    op(1, spa(1, 640 + 3), 0, 32'hABCD_E0C0, 0, 0, "R8 dtlb xlate write");
    op(1, spa(2, 512 + TLB_N - 1), 0, 32'h8765_4001, 0, 0, "R8 itlb last match");
    op(1, spa(2, 640), 0, 32'h0F0F_0F0F, 0, 0, "R8 itlb xlate");
    op(0, spa(1, 512 + 3), 0, 0, 0, 0, "R8 dtlb match read");
    op(0, spa(1, 640 + 3), 0, 0, 0, 0, "R8 dtlb xlate read");
    op(0, spa(2, 512 + TLB_N - 1), 0, 0, 0, 0, "R8 itlb match read");
    op(1, spa(1, 512 + 3), 0, 32'h0000_0000, 0, 0, "R9 dtlb invalidate");
    op(1, spa(2, 0), 16'(512 + TLB_N - 1), 32'h0000_0010, 0, 0, "R9 itlb invalidate");
    op(1, spa(1, 512 + 3), 0, 32'hFFFF_FFFF, 0, 0, "R9 valid write no flush");

    // R10: ignored ways and gaps
    op(1, spa(1, 768), 0, 32'h5555_5555, 32'hCAFE_0001, 0, "R10 dtlb way1 write");
    op(0, spa(1, 768), 0, 0, 32'hCAFE_0002, 0, "R10 dtlb way1 read");
    op(1, spa(2, 1535), 0, 32'h6666_6666, 32'hCAFE_0003, 0, "R10 itlb way3 write");
    op(1, spa(1, 512 + TLB_N), 0, 32'h7777_7776, 32'hCAFE_0004, 0, "R10 past entries");
    op(0, spa(1, 512), 0, 0, 0, 0, "R10 entry0 untouched");
    op(0, spa(2, 640 + TLB_N), 0, 0, 32'hCAFE_0005, 0, "R10 xlate gap read");
    op(0, spa(5, 3), 0, 0, 32'hCAFE_0006, 0, "R10 unmapped group");

    // R11: timer side port
    op(1, spa(10, 0), 0, 32'h4000_0010, 0, 0, "R11 timer mode write");
    op(1, spa(10, 1), 0, 32'h0000_0123, 0, 0, "R11 timer count write");
    op(0, spa(10, 0), 0, 0, 0, 0, "R11 timer mode read");
    op(0, spa(10, 1), 0, 0, 0, 0, "R11 timer count read");

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] adr;
      logic [31:0] dat;
      int pick;
      pick = int'($urandom_range(0, 13));
      dat = $urandom;
      case (pick)
        0: adr = spa(0, 17);
        1: adr = spa(9, 0);
        2: adr = spa(9, 2);
        3: adr = spa(1, 512 + int'($urandom_range(0, TLB_N - 1)));
        4: adr = spa(2, 512 + int'($urandom_range(0, TLB_N - 1)));
        5: adr = spa(1, 640 + int'($urandom_range(0, TLB_N - 1)));
        6: adr = spa(2, 640 + int'($urandom_range(0, TLB_N - 1)));
        7: adr = spa(1, 768 + int'($urandom_range(0, 767)));
        8: adr = spa(0, 16);
        9: adr = spa(0, 64);
        10: adr = spa(10, int'($urandom_range(0, 1)));
        11: adr = spa(int'($urandom_range(0, 31)), int'($urandom_range(0, 2047)));
        12: adr = spa(0, 17);
        default: adr = spa(0, 48);
      endcase
      if (pick == 12) dat = {dat[31:7], 7'h0} | (dat & 32'h61);
      op(bit'($urandom_range(0, 1)), adr, 16'h0, dat, $urandom,
         $urandom & $urandom & $urandom, "R1 R2 R4 R6 R7 R8 R9 R10 mixed");
    end

    finishRun();
  end
endmodule